// File: doc/BRIEF.md
# Flash Sector Protection Controller

This block holds the protection state for a serial flash array of sixteen sectors. It sits behind the serial front end, which delivers complete bytes together with two single-cycle strobes: one for the start of a chip-select frame and one for its end. From that byte stream it recognises four-byte protection sequences and a readout command. It holds a sixteen-entry protection table and a software protection flag. It combines these with an active-low write-protect pin to decide, for every region of the array, whether program and erase are allowed.

Sector 0 is split into two regions. Pages 0-7 form one region and pages 8-255 form the other, so the block has seventeen region permissions. The array sequencer raises a request for a page operation or for a chip erase. One cycle later the block answers with a grant mask: either a single region bit, or the set of regions a chip erase may touch. Table wipes and table loads are self-timed, and a fixed busy counter stands in for that time. While the counter runs, the block drops new frames and denies all requests.

Top module: `flash_protect_ctrl`

## Requirements
- R1: The frame 3Dh 2Ah 7Fh A9h, exactly four bytes long, sets the software flag in the cycle after its end strobe, whatever the state of the write-protect pin.
- R2: The frame 3Dh 2Ah 7Fh 9Ah, exactly four bytes long, clears the software flag at its end strobe only if wp_ni is high at that moment. Otherwise the frame has no effect.
- R3: prot_on_o is high whenever the software flag is set or wp_ni is low. Releasing wp_ni therefore leaves protection on if the flag was set before or while the pin was low.
- R4: The frame 3Dh 2Ah 7Fh CFh, exactly four bytes long, sets all sixteen table entries to FFh at its end strobe, whether or not protection is on. It does so only with wp_ni high, and then starts the busy period. With wp_ni low the frame does nothing.
- R5: In a frame starting 3Dh 2Ah 7Fh FCh, the k-th following byte (k from 0) is staged for entry k mod 16. At the end strobe, staged entries replace their table values only if wp_ni is high, which also starts the busy period. Entries that were not staged keep their value.
- R6: In a frame starting with 32h, the 5th to 20th bytes each make rd_valid_o pulse one cycle later, carrying table entries 0 to 15 in order. Later bytes produce no pulse.
- R7: allow_o bit 0 covers pages 0-7 and is guarded by entry 0 bits 7:6. Bit 1 covers pages 8-255 and is guarded by entry 0 bits 5:4. Bit s+1 covers sector s (s from 1 to 15) and is guarded by all of entry s. A region is allowed when prot_on_o is low or all of its guard bits are zero. Any other guard value, FFh or not, counts as protected.
- R8: op_req_i with op_chip_i low gives grant_valid_o one cycle later, with grant_mask_o equal to the one-hot region bit of op_page_i if that region is allowed, and zero otherwise. The sector is taken from op_page_i[11:8].
- R9: op_req_i with op_chip_i high gives grant_mask_o equal to allow_o one cycle later.
- R10: busy_o stays high for 24 cycles after a wipe or load is committed. A frame started while busy_o is high is ignored entirely, and requests made while busy_o is high get a zero mask.
- R11: After reset the software flag is clear, all entries are FFh, busy_o is low, and grant_valid_o and rd_valid_o are low.
- R12: A 3Dh 2Ah 7Fh frame that sets, clears or wipes has no effect if its length is not exactly four bytes. A frame with an unknown fourth byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_start_i | input | 1 | Strobe: chip-select frame begins |
| cs_end_i | input | 1 | Strobe: chip-select frame ends |
| byte_valid_i | input | 1 | Strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte |
| wp_ni | input | 1 | Write-protect pin, active low |
| op_req_i | input | 1 | Program or erase request from the array sequencer |
| op_chip_i | input | 1 | Request is a chip erase |
| op_page_i | input | 12 | Target page of a page request |
| prot_on_o | output | 1 | Protection in force |
| allow_o | output | 17 | Per-region program/erase permission |
| busy_o | output | 1 | Table wipe or load in progress |
| grant_valid_o | output | 1 | Grant answer valid |
| grant_mask_o | output | 17 | Regions granted to the answered request |
| rd_valid_o | output | 1 | Readout byte valid |
| rd_data_o | output | 8 | Readout byte |

## Verification
The assertions assume that the front end never raises more than one of cs_start_i, byte_valid_i and cs_end_i in the same cycle. They also assume that bytes arrive only between a start strobe and an end strobe. The bench keeps to this because every frame is built by one task that raises the strobes in separate cycles. wp_ni and requests only change outside frames, and a cycle-level model is compared with every output on each clock.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam logic [7:0] PFX0     = 8'h3D;
  localparam logic [7:0] PFX1     = 8'h2A;
  localparam logic [7:0] PFX2     = 8'h7F;
  localparam logic [7:0] SUB_ON   = 8'hA9;
  localparam logic [7:0] SUB_OFF  = 8'h9A;
  localparam logic [7:0] SUB_WIPE = 8'hCF;
  localparam logic [7:0] SUB_LOAD = 8'hFC;
  localparam logic [7:0] OPC_DUMP = 8'h32;

  typedef enum logic [2:0] {
    K_NONE, K_ON, K_OFF, K_WIPE, K_LOAD, K_DUMP
  } kind_e;
endpackage

// File: rtl/fpc_cmd_decode.sv
module fpc_cmd_decode
  import fpc_pkg::*;
#(
  parameter int NUM_SECT = 16,
  parameter int RD_DUMMY = 3,
  localparam int SECT_W = $clog2(NUM_SECT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_start_i,
  input  logic              cs_end_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              busy_i,
  output logic              on_o,
  output logic              off_o,
  output logic              wipe_o,
  output logic              load_end_o,
  output logic              ld_we_o,
  output logic [SECT_W-1:0] ld_idx_o,
  output logic [7:0]        ld_data_o,
  output logic              rd_req_o,
  output logic [SECT_W-1:0] rd_idx_o
);
  localparam int RD_BASE = 1 + RD_DUMMY;
  localparam int CNT_W   = $clog2(RD_BASE + NUM_SECT + 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0][7:0]   hdr_q;
  kind_e             kind_q;
  kind_e             kind_4th;
  logic [SECT_W-1:0] widx_q;
  logic              take;
  logic              end_ok;
  logic              exact4;

  assign take   = active_q & byte_valid_i;
  assign end_ok = active_q & cs_end_i;
  assign exact4 = (cnt_q == CNT_W'(4));

  always_comb begin
    kind_4th = K_NONE;
    if (hdr_q[0] == PFX0 && hdr_q[1] == PFX1 && hdr_q[2] == PFX2) begin
      case (byte_i)
        SUB_ON:   kind_4th = K_ON;
        SUB_OFF:  kind_4th = K_OFF;
        SUB_WIPE: kind_4th = K_WIPE;
        SUB_LOAD: kind_4th = K_LOAD;
        default:  kind_4th = K_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      hdr_q    <= '0;
      kind_q   <= K_NONE;
      widx_q   <= '0;
    end else if (cs_start_i) begin
      active_q <= ~busy_i;
      cnt_q    <= '0;
      kind_q   <= K_NONE;
      widx_q   <= '0;
    end else begin
      if (take) begin
        if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q < CNT_W'(3)) hdr_q[cnt_q[1:0]] <= byte_i;
        if (cnt_q == '0) kind_q <= (byte_i == OPC_DUMP) ? K_DUMP : K_NONE;
        else if (cnt_q == CNT_W'(3) && kind_q != K_DUMP) kind_q <= kind_4th;
        if (kind_q == K_LOAD) widx_q <= widx_q + SECT_W'(1);
      end
      if (cs_end_i) active_q <= 1'b0;
    end
  end

  assign ld_we_o    = take && kind_q == K_LOAD;
  assign ld_idx_o   = widx_q;
  assign ld_data_o  = byte_i;
  assign rd_req_o   = take && kind_q == K_DUMP && cnt_q >= CNT_W'(RD_BASE)
                      && cnt_q < CNT_W'(RD_BASE + NUM_SECT);
  assign rd_idx_o   = SECT_W'(cnt_q - CNT_W'(RD_BASE));
  assign on_o       = end_ok && exact4 && kind_q == K_ON;
  assign off_o      = end_ok && exact4 && kind_q == K_OFF;
  assign wipe_o     = end_ok && exact4 && kind_q == K_WIPE;
  assign load_end_o = end_ok && kind_q == K_LOAD;
endmodule

// File: rtl/fpc_prot_store.sv
module fpc_prot_store #(
  parameter int NUM_SECT = 16,
  parameter int BUSY_CYC = 24,
  localparam int SECT_W = $clog2(NUM_SECT),
  localparam int BSY_W  = $clog2(BUSY_CYC + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wp_ni,
  input  logic                     on_i,
  input  logic                     off_i,
  input  logic                     wipe_i,
  input  logic                     load_end_i,
  input  logic                     ld_we_i,
  input  logic [SECT_W-1:0]        ld_idx_i,
  input  logic [7:0]               ld_data_i,
  output logic [NUM_SECT-1:0][7:0] entry_o,
  output logic                     sw_en_o,
  output logic                     busy_o
);
  logic             sw_q;
  logic [BSY_W-1:0] bcnt_q;
  logic             wipe_go;
  logic             load_go;

  assign wipe_go = wipe_i & wp_ni;
  assign load_go = load_end_i & wp_ni;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_ent
    logic [7:0] ent_q;
    logic [7:0] stg_q;
    logic       stg_vld_q;
    logic       hit;

    assign hit = ld_we_i && ld_idx_i == SECT_W'(s);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q     <= 8'hFF;
        stg_q     <= 8'h00;
        stg_vld_q <= 1'b0;
      end else begin
        if (hit) begin
          stg_q     <= ld_data_i;
          stg_vld_q <= 1'b1;
        end else if (load_end_i) begin
          stg_vld_q <= 1'b0;
        end
        if (wipe_go) ent_q <= 8'hFF;
        else if (load_go && stg_vld_q) ent_q <= stg_q;
      end
    end

    assign entry_o[s] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= 1'b0;
      bcnt_q <= '0;
    end else begin
      if (on_i) sw_q <= 1'b1;
      else if (off_i && wp_ni) sw_q <= 1'b0;
      if (wipe_go || load_go) bcnt_q <= BSY_W'(BUSY_CYC);
      else if (bcnt_q != '0) bcnt_q <= bcnt_q - BSY_W'(1);
    end
  end

  assign sw_en_o = sw_q;
  assign busy_o  = (bcnt_q != '0);
endmodule

// File: rtl/fpc_region_map.sv
module fpc_region_map #(
  parameter int NUM_SECT = 16
) (
  input  logic [NUM_SECT-1:0][7:0] entry_i,
  input  logic                     prot_on_i,
  output logic [NUM_SECT:0]        allow_o
);
  logic unused_lo;
  assign unused_lo = ^entry_i[0][3:0];

  assign allow_o[0] = ~prot_on_i | (entry_i[0][7:6] == 2'b00);
  assign allow_o[1] = ~prot_on_i | (entry_i[0][5:4] == 2'b00);

  for (genvar s = 1; s < NUM_SECT; s++) begin : g_sect
    assign allow_o[s+1] = ~prot_on_i | (entry_i[s] == 8'h00);
  end
endmodule

// File: rtl/flash_protect_ctrl.sv
module flash_protect_ctrl #(
  parameter int NUM_SECT   = 16,
  parameter int PAGE_W     = 12,
  parameter int SUB0_PAGES = 8,
  parameter int RD_DUMMY   = 3,
  parameter int BUSY_CYC   = 24,
  localparam int NUM_RGN   = NUM_SECT + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_start_i,
  input  logic               cs_end_i,
  input  logic               byte_valid_i,
  input  logic [7:0]         byte_i,
  input  logic               wp_ni,
  input  logic               op_req_i,
  input  logic               op_chip_i,
  input  logic [PAGE_W-1:0]  op_page_i,
  output logic               prot_on_o,
  output logic [NUM_RGN-1:0] allow_o,
  output logic               busy_o,
  output logic               grant_valid_o,
  output logic [NUM_RGN-1:0] grant_mask_o,
  output logic               rd_valid_o,
  output logic [7:0]         rd_data_o
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int OFF_W  = PAGE_W - SECT_W;
  localparam int RGN_W  = $clog2(NUM_RGN);

  logic                     on_s, off_s, wipe_s, load_end_s, ld_we_s, rd_req_s;
  logic [SECT_W-1:0]        ld_idx_s, rd_idx_s;
  logic [7:0]               ld_data_s;
  logic [NUM_SECT-1:0][7:0] entry_s;
  logic                     sw_en_s;
  logic                     busy_s;

  fpc_cmd_decode #(.NUM_SECT(NUM_SECT), .RD_DUMMY(RD_DUMMY)) u_dec (
    .clk_i, .rst_ni, .cs_start_i, .cs_end_i, .byte_valid_i, .byte_i,
    .busy_i     (busy_s),
    .on_o       (on_s),
    .off_o      (off_s),
    .wipe_o     (wipe_s),
    .load_end_o (load_end_s),
    .ld_we_o    (ld_we_s),
    .ld_idx_o   (ld_idx_s),
    .ld_data_o  (ld_data_s),
    .rd_req_o   (rd_req_s),
    .rd_idx_o   (rd_idx_s)
  );

  fpc_prot_store #(.NUM_SECT(NUM_SECT), .BUSY_CYC(BUSY_CYC)) u_store (
    .clk_i, .rst_ni, .wp_ni,
    .on_i       (on_s),
    .off_i      (off_s),
    .wipe_i     (wipe_s),
    .load_end_i (load_end_s),
    .ld_we_i    (ld_we_s),
    .ld_idx_i   (ld_idx_s),
    .ld_data_i  (ld_data_s),
    .entry_o    (entry_s),
    .sw_en_o    (sw_en_s),
    .busy_o     (busy_s)
  );

  assign prot_on_o = sw_en_s | ~wp_ni;
  assign busy_o    = busy_s;

  fpc_region_map #(.NUM_SECT(NUM_SECT)) u_map (
    .entry_i   (entry_s),
    .prot_on_i (prot_on_o),
    .allow_o   (allow_o)
  );

  // region of the requested page; sector 0 splits at SUB0_PAGES
  logic [SECT_W-1:0]  sect;
  logic [OFF_W-1:0]   off;
  logic [RGN_W-1:0]   rgn;
  logic [NUM_RGN-1:0] sel;
  logic [NUM_RGN-1:0] mask_n;

  assign sect = op_page_i[PAGE_W-1 -: SECT_W];
  assign off  = op_page_i[OFF_W-1:0];

  always_comb begin
    if (sect == '0) rgn = (off < OFF_W'(SUB0_PAGES)) ? RGN_W'(0) : RGN_W'(1);
    else            rgn = RGN_W'(sect) + RGN_W'(1);
    sel      = '0;
    sel[rgn] = 1'b1;
    if (busy_s)         mask_n = '0;
    else if (op_chip_i) mask_n = allow_o;
    else                mask_n = sel & allow_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_mask_o  <= '0;
      rd_valid_o    <= 1'b0;
      rd_data_o     <= '0;
    end else begin
      grant_valid_o <= op_req_i;
      grant_mask_o  <= op_req_i ? mask_n : '0;
      rd_valid_o    <= rd_req_s;
      if (rd_req_s) rd_data_o <= entry_s[rd_idx_s];
    end
  end
endmodule

// File: rtl/flash_protect_ctrl_chk.sv
module flash_protect_ctrl_chk #(
  parameter int NUM_RGN = 17
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wp_ni,
  input logic               byte_valid_i,
  input logic               op_req_i,
  input logic               op_chip_i,
  input logic               prot_on_o,
  input logic [NUM_RGN-1:0] allow_o,
  input logic               busy_o,
  input logic               grant_valid_o,
  input logic [NUM_RGN-1:0] grant_mask_o,
  input logic               rd_valid_o
);
  AST_WP_FORCES_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |-> prot_on_o); // R3

  AST_OFF_ALLOWS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_on_o |-> (&allow_o)); // R7

  AST_REQ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_i |=> grant_valid_o); // R8

  AST_GRANT_WITHIN_ALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ((grant_mask_o & ~$past(allow_o)) == '0)); // R9

  AST_PAGE_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !$past(op_chip_i)) |-> $onehot0(grant_mask_o)); // R8

  AST_BUSY_DENIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && $past(busy_o)) |-> (grant_mask_o == '0)); // R10

  AST_RD_FOLLOWS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(byte_valid_i)); // R6

  AST_RD_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !$past(busy_o)); // R10
endmodule

bind flash_protect_ctrl flash_protect_ctrl_chk #(.NUM_RGN(NUM_RGN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wp_ni         (wp_ni),
  .byte_valid_i  (byte_valid_i),
  .op_req_i      (op_req_i),
  .op_chip_i     (op_chip_i),
  .prot_on_o     (prot_on_o),
  .allow_o       (allow_o),
  .busy_o        (busy_o),
  .grant_valid_o (grant_valid_o),
  .grant_mask_o  (grant_mask_o),
  .rd_valid_o    (rd_valid_o)
);

// File: tb/flash_protect_ctrl_test.sv
`timescale 1ns/1ps
module flash_protect_ctrl_test;
  localparam int NS   = 16;
  localparam int NR   = NS + 1;
  localparam int BUSY = 24;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_start = 1'b0, cs_end = 1'b0, bv = 1'b0, wp_n = 1'b1;
  logic op_req = 1'b0, op_chip = 1'b0;
  logic [7:0]  bd = '0;
  logic [11:0] op_page = '0;
  logic prot_on, busy, gv, rdv;
  logic [NR-1:0] allow, gm;
  logic [7:0] rdd;

  always #2.5 clk = ~clk;

  flash_protect_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_start_i(cs_start), .cs_end_i(cs_end),
    .byte_valid_i(bv), .byte_i(bd), .wp_ni(wp_n), .op_req_i(op_req),
    .op_chip_i(op_chip), .op_page_i(op_page), .prot_on_o(prot_on),
    .allow_o(allow), .busy_o(busy), .grant_valid_o(gv), .grant_mask_o(gm),
    .rd_valid_o(rdv), .rd_data_o(rdd)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit         m_flag, m_act, m_rdv, m_gv;
  logic [7:0] m_ent[NS];
  logic [7:0] m_stg[NS];
  bit         m_smk[NS];
  int         m_busy;
  logic [7:0] m_rdd;
  logic [NR-1:0] m_gm;
  logic [7:0] q[$];
  logic [7:0] rd_log[$];

  function automatic logic [NR-1:0] m_allow();
    logic [NR-1:0] a;
    bit p;
    p = m_flag || !wp_n;
    a[0] = !p || m_ent[0][7:6] == 2'b00;
    a[1] = !p || m_ent[0][5:4] == 2'b00;
    for (int s = 1; s < NS; s++) a[s+1] = !p || m_ent[s] == 8'h00;
    return a;
  endfunction

  function automatic bit m_pfx();
    return q.size() >= 4 && q[0] == 8'h3D && q[1] == 8'h2A && q[2] == 8'h7F;
  endfunction

  always @(posedge clk) begin : model
    logic [NR-1:0] al;
    int p, rg, nb;
    if (!rst_ni) begin
      m_flag = 0; m_act = 0; m_rdv = 0; m_gv = 0; m_gm = '0; m_busy = 0; m_rdd = '0;
      for (int s = 0; s < NS; s++) begin m_ent[s] = 8'hFF; m_smk[s] = 0; m_stg[s] = '0; end
      q.delete();
    end else begin
      al = m_allow();
      m_gv = op_req; m_gm = '0;
      if (op_req && m_busy == 0) begin
        if (op_chip) m_gm = al;
        else begin
          if (op_page[11:8] == 0) rg = (op_page[7:0] < 8) ? 0 : 1;
          else rg = int'(op_page[11:8]) + 1;
          m_gm[rg] = al[rg];
        end
      end
      m_rdv = 0;
      nb = m_busy;
      if (m_busy > 0) m_busy--;
      if (cs_start) begin m_act = (nb == 0); q.delete(); end
      if (bv && m_act) begin
        q.push_back(bd);
        p = q.size() - 1;
        if (q[0] == 8'h32 && p >= 4 && p < 20) begin m_rdv = 1; m_rdd = m_ent[p-4]; end
        if (p >= 4 && m_pfx() && q[3] == 8'hFC) begin m_stg[(p-4)%NS] = bd; m_smk[(p-4)%NS] = 1; end
      end
      if (cs_end && m_act) begin
        if (m_pfx()) begin
          if (q.size() == 4 && q[3] == 8'hA9) m_flag = 1;
          if (q.size() == 4 && q[3] == 8'h9A && wp_n) m_flag = 0;
          if (q.size() == 4 && q[3] == 8'hCF && wp_n) begin
            for (int s = 0; s < NS; s++) m_ent[s] = 8'hFF;
            m_busy = BUSY;
          end
          if (q[3] == 8'hFC) begin
            if (wp_n) begin
              for (int s = 0; s < NS; s++) if (m_smk[s]) m_ent[s] = m_stg[s];
              m_busy = BUSY;
            end
            for (int s = 0; s < NS; s++) m_smk[s] = 0;
          end
        end
        m_act = 0;
      end
      #1;
      chk(prot_on === (m_flag || !wp_n), "R3 prot_on_o", prot_on, m_flag || !wp_n);
      chk(allow === m_allow(), "R7 allow_o", allow, m_allow());
      chk(busy === (m_busy != 0), "R10 busy_o", busy, m_busy != 0);
      chk(gv === m_gv && gm === m_gm, "R8/R9 grant", {gv, gm}, {m_gv, m_gm});
      chk(rdv === m_rdv, "R6 rd_valid_o", rdv, m_rdv);
      if (m_rdv) chk(rdd === m_rdd, "R6 rd_data_o", rdd, m_rdd);
      if (rdv) rd_log.push_back(rdd);
    end
  end

  task automatic txn(input bq_t b);
    @(negedge clk); cs_start = 1;
    @(negedge clk); cs_start = 0;
    foreach (b[i]) begin bv = 1; bd = b[i]; @(negedge clk); end
    bv = 0; cs_end = 1;
    @(negedge clk); cs_end = 0;
    @(negedge clk);
  endtask

  task automatic req(input bit chip, input logic [11:0] pg, output logic [NR-1:0] m);
    @(negedge clk); op_req = 1; op_chip = chip; op_page = pg;
    @(negedge clk); op_req = 0; op_chip = 0;
    m = gm;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    logic [NR-1:0] m;
    bq_t b;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    chk(prot_on == 0 && busy == 0, "R11 reset prot/busy", {prot_on, busy}, 0);
    chk(gv == 0 && rdv == 0, "R11 reset strobes", {gv, rdv}, 0);
    chk(allow == '1, "R11 reset allow", allow, {NR{1'b1}});

    req(0, 12'h005, m); chk(m == 17'h1, "R8 page grant unprotected", m, 17'h1);
    req(1, 12'h000, m); chk(m == '1, "R9 chip grant unprotected", m, {NR{1'b1}});

    txn('{8'h3D, 8'h2A, 8'h7F, 8'hA9});
    chk(prot_on == 1, "R1 enable", prot_on, 1);
    chk(allow == '0, "R7 all FF protected", allow, 0);
    req(0, 12'h123, m); chk(m == '0, "R8 protected page denied", m, 0);

    b = '{8'h32, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < 18; i++) b.push_back(8'h00);
    rd_log.delete();
    txn(b);
    chk(rd_log.size() == 16, "R6 readout length", rd_log.size(), 16);

    b = '{8'h3D, 8'h2A, 8'h7F, 8'hFC, 8'hC0, 8'h00, 8'h5A};
    for (int i = 0; i < 13; i++) b.push_back(8'hFF);
    b.push_back(8'h30);
    txn(b);
    chk(busy == 1, "R10 busy after load", busy, 1);
    txn('{8'h3D, 8'h2A, 8'h7F, 8'h9A});
    chk(prot_on == 1, "R10 frame while busy ignored", prot_on, 1);
    req(1, 12'h000, m); chk(m == '0, "R10 request while busy", m, 0);
    wait_idle();
    chk(allow == 17'h5, "R5 load with wrap / R7 split sector 0", allow, 17'h5);
    req(0, 12'h003, m); chk(m == 17'h1, "R8 subsector 0a", m, 17'h1);
    req(0, 12'h009, m); chk(m == 17'h0, "R8 subsector 0b", m, 0);
    req(0, 12'h100, m); chk(m == 17'h4, "R8 sector 1", m, 17'h4);

    rd_log.delete();
    b = '{8'h32, 8'h11, 8'h22, 8'h33};
    for (int i = 0; i < 16; i++) b.push_back(8'h00);
    txn(b);
    chk(rd_log.size() == 16 && rd_log[0] == 8'h30 && rd_log[1] == 8'h00 && rd_log[2] == 8'h5A
        && rd_log[15] == 8'hFF, "R6 readout contents", rd_log.size() > 2 ? rd_log[2] : 0, 8'h5A);

    txn('{8'h3D, 8'h2A, 8'h7F, 8'h9A, 8'h00});
    chk(prot_on == 1, "R12 five-byte disable ignored", prot_on, 1);
    txn('{8'h3D, 8'h2A, 8'h7F, 8'h00});
    chk(prot_on == 1 && busy == 0, "R12 unknown frame ignored", {prot_on, busy}, 2'b10);

    @(negedge clk); wp_n = 0;
    txn('{8'h3D, 8'h2A, 8'h7F, 8'h9A});
    txn('{8'h3D, 8'h2A, 8'h7F, 8'hCF});
    chk(busy == 0, "R4 wipe under write-protect ignored", busy, 0);
    @(negedge clk); wp_n = 1;
    @(negedge clk);
    chk(prot_on == 1, "R2 disable under write-protect ignored / R3 flag kept", prot_on, 1);

    txn('{8'h3D, 8'h2A, 8'h7F, 8'h9A});
    chk(prot_on == 0, "R2 disable", prot_on, 0);
    @(negedge clk); wp_n = 0;
    @(negedge clk);
    chk(prot_on == 1, "R3 pin alone protects", prot_on, 1);
    chk(allow == 17'h5, "R4 table intact after blocked wipe", allow, 17'h5);
    @(negedge clk); wp_n = 1;
    @(negedge clk);
    chk(prot_on == 0, "R3 release without flag", prot_on, 0);

    @(negedge clk); wp_n = 0;
    txn('{8'h3D, 8'h2A, 8'h7F, 8'hA9});
    @(negedge clk); wp_n = 1;
    @(negedge clk);
    chk(prot_on == 1, "R3 enable during pin assertion persists", prot_on, 1);
    txn('{8'h3D, 8'h2A, 8'h7F, 8'h9A});

    txn('{8'h3D, 8'h2A, 8'h7F, 8'hCF});
    chk(busy == 1, "R4 wipe with protection off", busy, 1);
    wait_idle();
    txn('{8'h3D, 8'h2A, 8'h7F, 8'hA9});
    chk(allow == '0, "R4 all entries FF", allow, 0);

    @(negedge clk); wp_n = 0;
    b = '{8'h3D, 8'h2A, 8'h7F, 8'hFC};
    for (int i = 0; i < 16; i++) b.push_back(8'h00);
    txn(b);
    @(negedge clk); wp_n = 1;
    @(negedge clk);
    chk(busy == 0 && allow == '0, "R5 load under write-protect ignored", allow, 0);

    txn('{8'h3D, 8'h2A, 8'h7F, 8'hFC, 8'h00, 8'h00});
    wait_idle();
    chk(allow == 17'h7, "R5 partial load", allow, 17'h7);
    req(1, 12'h000, m); chk(m == 17'h7, "R9 chip erase mask", m, 17'h7);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule